// File: doc/BRIEF.md
# CAN Receive Message Queue with Word-Sequenced Host Readout

This block queues received CAN frames and hands them to a host processor one 32-bit word at a time. The frame receiver delivers a complete frame in a single transfer: identifier fields, length code and eight payload bytes. The block packs the frame into a four-word record and stores it in a circular buffer of `DEPTH` entries.

The host reads every frame through one read port. Successive reads return the identifier word, the length-code word, the first data word and then the second data word of the oldest frame. The entry is released only after the fourth read. This holds whatever the length code says, so the host always performs four reads per frame. A read while the queue is empty moves nothing. Host writes to the port are discarded.

The ingress side is a valid/ready stream. `in_ready` is high whenever a slot is free. A CAN receiver cannot pause the bus, so a frame offered while `in_ready` is low is not held back. It is dropped, and the sticky `overflow` flag is raised. Stored frames are cleared by reset only. No bus-state or mode change on the controller affects them.

Top module: `can_rxq`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `overflow` is 0 and `in_ready` is 1.
- R2: The first word of a frame is packed from most significant bit downward as follows: `rd_data[31:21]` holds the upper identifier bits `in_id_hi`, bit 20 holds `in_srr_rtr`, bit 19 holds `in_ide`, bits 18:1 hold the extended identifier bits `in_id_lo`, and bit 0 holds `in_rtr`.
- R3: The second word carries the length code in `rd_data[31:28]`, and bits 27:0 read as zero, for every length code 0 to 15.
- R4: In the third word, payload byte 0 (`in_data[63:56]`) sits in `rd_data[31:24]` and byte 3 sits in `rd_data[7:0]`. The fourth word likewise carries bytes 4 to 7, with byte 4 in `rd_data[31:24]`.
- R5: A frame stays at the head of the queue through exactly four host reads. `empty` and the head entry change only on the fourth read, regardless of the length code.
- R6: Frames leave the queue in arrival order, and up to `DEPTH` frames can be held at once.
- R7: With `DEPTH` frames stored, `full` is 1 and `in_ready` is 0. `full` and `empty` are never both 1.
- R8: A frame offered while the queue is full is discarded. `overflow` becomes 1 and stays 1 until reset, and the stored frames are unchanged.
- R9: A host read while the queue is empty moves neither the entry pointer nor the word position. The next frame written reads out from its first word.
- R10: A host write (`host_wr` with any `host_wdata`) has no effect on the stored data, the word position or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receiver offers a complete frame |
| in_ready | output | 1 | A free slot exists; a frame offered while low is dropped |
| in_id_hi | input | 11 | Upper identifier bits |
| in_srr_rtr | input | 1 | Substitute-remote / remote flag of the base format |
| in_ide | input | 1 | Extended identifier flag |
| in_id_lo | input | 18 | Extended identifier bits |
| in_rtr | input | 1 | Remote request flag of the extended format |
| in_dlc | input | 4 | Length code |
| in_data | input | 64 | Payload, byte 0 in bits 63:56 |
| host_rd | input | 1 | Host read strobe; `rd_data` is valid in the same cycle |
| host_wr | input | 1 | Host write strobe (ignored) |
| host_wdata | input | 32 | Host write data (ignored) |
| rd_data | output | 32 | Current word of the oldest frame |
| empty | output | 1 | No frame stored |
| full | output | 1 | All slots in use |
| overflow | output | 1 | Sticky: a frame was dropped |

## Verification
The embedded assertions watch several rules on every cycle:
- the occupancy never exceeds `DEPTH`;
- the full and empty flags never coincide;
- the overflow flag is sticky;
- an empty read leaves the pointers and the word position alone;
- a lone host write disturbs nothing;
- the head pointer advances only on a fourth read.

Only the bench's scenarios can show that the bit packing of each word is correct. The same holds for arrival order across fill levels, dropping on overflow with the older frames intact, and the four-read rule at every length code. The bench computes every expected word from the frame index by arithmetic.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;
  localparam int WORDS   = 4;
  localparam int WORD_W  = 32;
  localparam int REC_W   = WORDS * WORD_W;

  typedef struct packed {
    logic [10:0] id_hi;
    logic        srr_rtr;
    logic        ide;
    logic [17:0] id_lo;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] payload;
  } can_frame_t;

  typedef logic [REC_W-1:0] rec_t;
endpackage

// File: rtl/can_rxq_pack.sv
module can_rxq_pack
  import can_rxq_pkg::*;
(
  input  can_frame_t frame,
  output rec_t       rec
);
  logic [WORD_W-1:0] w [WORDS];

  always_comb begin
    w[0] = {frame.id_hi, frame.srr_rtr, frame.ide, frame.id_lo, frame.rtr};
    w[1] = {frame.dlc, 28'd0};
    w[2] = frame.payload[63:32];
    w[3] = frame.payload[31:0];
  end

  // word 0 occupies the top of the record
  for (genvar i = 0; i < WORDS; i++) begin : g_place
    assign rec[(WORDS-1-i)*WORD_W +: WORD_W] = w[i];
  end
endmodule

// File: rtl/can_rxq_store.sv
module can_rxq_store
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 4
)(
  input  logic clk,
  input  logic rst_n,
  input  logic push_valid,
  input  rec_t push_rec,
  input  logic pop,
  output rec_t head_rec,
  output logic in_ready,
  output logic full,
  output logic empty,
  output logic overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rec_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign in_ready = !full;
  assign do_push  = push_valid && !full;
  assign do_pop   = pop && !empty;
  assign head_rec = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_valid && full) overflow <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R6
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_DROP_KEEPS_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full) |=> $stable(wr_ptr)); // R8
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(rd_ptr)); // R9
endmodule

// File: rtl/can_rxq_wsel.sv
module can_rxq_wsel
  import can_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              empty,
  input  rec_t              head_rec,
  output logic [WORD_W-1:0] rd_data,
  output logic              pop
);
  localparam int IDX_W = $clog2(WORDS);

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] words [WORDS];
  logic              take;

  for (genvar i = 0; i < WORDS; i++) begin : g_split
    assign words[i] = head_rec[(WORDS-1-i)*WORD_W +: WORD_W];
  end

  assign take    = rd_req && !empty;
  assign pop     = take && (idx == IDX_W'(WORDS-1));
  assign rd_data = words[idx];

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (take) idx <= idx + 1'b1;  // wraps to 0 after the last word
  end

  AST_EMPTY_READ_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> $stable(idx)); // R9
  AST_LAST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (idx == '0)); // R5
endmodule

// File: rtl/can_rxq.sv
module can_rxq
  import can_rxq_pkg::*;
#(
  parameter int DEPTH = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [10:0] in_id_hi,
  input  logic        in_srr_rtr,
  input  logic        in_ide,
  input  logic [17:0] in_id_lo,
  input  logic        in_rtr,
  input  logic [3:0]  in_dlc,
  input  logic [63:0] in_data,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] rd_data,
  output logic        empty,
  output logic        full,
  output logic        overflow
);
  can_frame_t frame;
  rec_t       new_rec, head_rec;
  logic       pop;
  logic       unused_host_write;

  // host writes reach no state
  assign unused_host_write = host_wr ^ (^host_wdata);

  assign frame = '{id_hi: in_id_hi, srr_rtr: in_srr_rtr, ide: in_ide,
                   id_lo: in_id_lo, rtr: in_rtr, dlc: in_dlc,
                   payload: in_data};

  can_rxq_pack u_pack (.frame(frame), .rec(new_rec));

  can_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_rec(new_rec), .pop(pop),
    .head_rec(head_rec), .in_ready(in_ready),
    .full(full), .empty(empty), .overflow(overflow)
  );

  can_rxq_wsel u_wsel (
    .clk(clk), .rst_n(rst_n),
    .rd_req(host_rd), .empty(empty), .head_rec(head_rec),
    .rd_data(rd_data), .pop(pop)
  );

  AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd && !in_valid) |=>
      ($stable(rd_data) && $stable(empty) && $stable(full) && $stable(overflow))); // R10
  AST_POP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd && !in_valid) |=> ($stable(empty) && $stable(rd_data))); // R5
endmodule

// File: tb/can_rxq_bench.sv
module can_rxq_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] in_id_hi = '0;
  logic        in_srr_rtr = 1'b0;
  logic        in_ide = 1'b0;
  logic [17:0] in_id_lo = '0;
  logic        in_rtr = 1'b0;
  logic [3:0]  in_dlc = '0;
  logic [63:0] in_data = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] rd_data;
  logic        empty, full, overflow;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_rxq #(.DEPTH(DEPTH)) u_can_rxq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id_hi(in_id_hi), .in_srr_rtr(in_srr_rtr), .in_ide(in_ide),
    .in_id_lo(in_id_lo), .in_rtr(in_rtr), .in_dlc(in_dlc), .in_data(in_data),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .rd_data(rd_data), .empty(empty), .full(full), .overflow(overflow)
  );

  // frame fields derived arithmetically from an index
  function automatic logic [10:0] f_idh(int k); return 11'((k * 37 + 5) & 11'h7FF); endfunction
  function automatic logic [17:0] f_idl(int k); return 18'((k * 12345 + 77) & 18'h3FFFF); endfunction
  function automatic logic [63:0] f_dat(int k);
    return 64'h0123_4567_89AB_CDEF ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15);
  endfunction
  function automatic logic [31:0] exp_word(int k, int w);
    logic [63:0] d;
    d = f_dat(k);
    case (w)
      0: return {f_idh(k), k[0], k[1], f_idl(k), k[2]};
      1: return {4'(k % 16), 28'd0};
      2: return {d[63:56], d[55:48], d[47:40], d[39:32]};
      default: return {d[31:24], d[23:16], d[15:8], d[7:0]};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(int k);
    @(negedge clk);
    in_id_hi = f_idh(k); in_srr_rtr = k[0]; in_ide = k[1];
    in_id_lo = f_idl(k); in_rtr = k[2]; in_dlc = 4'(k % 16);
    in_data = f_dat(k); in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic rd_word(string req, logic [31:0] exp);
    @(negedge clk);
    host_rd = 1'b1;
    #1 chk(req, rd_data, exp);
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic rd_frame(int k);
    for (int w = 0; w < 4; w++) begin
      rd_word(w == 0 ? "R2/R6 id word" : w == 1 ? "R3 dlc word" : "R4 data word",
              exp_word(k, w));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 overflow", 32'(overflow), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);

    // R9 reads on an empty queue move nothing
    @(negedge clk); host_rd = 1'b1;
    repeat (3) @(posedge clk);
    #1 host_rd = 1'b0;
    chk("R9 still empty", 32'(empty), 32'd1);
    push(1);
    // R5 frame stays through three reads, leaves on the fourth
    for (int w = 0; w < 3; w++) begin
      rd_word("R9/R2 word after empty read", exp_word(1, w));
      chk("R5 not released early", 32'(empty), 32'd0);
    end
    rd_word("R4 word 3", exp_word(1, 3));
    chk("R5 released on fourth read", 32'(empty), 32'd1);

    // R6 order at each fill level, R7 full
    k = 2;
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) push(k + i);
      @(negedge clk);
      chk("R7 full flag", 32'(full), 32'(n == DEPTH));
      chk("R7 in_ready", 32'(in_ready), 32'(n != DEPTH));
      for (int i = 0; i < n; i++) rd_frame(k + i);
      chk("R6 drained", 32'(empty), 32'd1);
      k += n;
    end

    // R3 every length code; R5 four reads regardless of code
    for (int j = 16; j < 32; j++) begin
      push(j);
      rd_frame(j);
      chk("R5 empty after four reads", 32'(empty), 32'd1);
    end

    // R10 host write mid-frame
    push(40);
    rd_word("R10 pre word0", exp_word(40, 0));
    rd_word("R10 pre word1", exp_word(40, 1));
    @(negedge clk); host_wr = 1'b1; host_wdata = 32'hDEAD_BEEF;
    @(posedge clk); #1 host_wr = 1'b0;
    @(negedge clk);
    chk("R10 flags", {29'd0, empty, full, overflow}, 32'd0);
    rd_word("R10 word2 after write", exp_word(40, 2));
    rd_word("R10 word3 after write", exp_word(40, 3));
    chk("R10 empty", 32'(empty), 32'd1);

    // R8 overflow drop
    for (int i = 0; i < DEPTH; i++) push(50 + i);
    @(negedge clk);
    chk("R8 no overflow yet", 32'(overflow), 32'd0);
    push(99);
    @(negedge clk);
    chk("R8 overflow set", 32'(overflow), 32'd1);
    chk("R7 full kept", 32'(full), 32'd1);
    for (int i = 0; i < DEPTH; i++) rd_frame(50 + i);
    chk("R8 dropped frame absent", 32'(empty), 32'd1);
    chk("R8 overflow sticky", 32'(overflow), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule